// File: doc/BRIEF.md
# Reseed Value Builder

This block assembles the value handed to a random-bit generator every time that generator is reseeded. The seeding half of the value comes from one of three places. The first is a 384-bit seed written by software as twelve 32-bit words. The second is a 128-bit test seed that software clocks in one bit per register write. The third is the raw output of an entropy source, which arrives on an input port. The other half holds a 384-bit personalization value, also written as twelve words, and it can be blanked to zeros by a control bit.

Software writes seed words, personalization words, a control register and a single-bit shift register through a simple word-wide register port. No seed or personalization word can be read back. A read anywhere in the window that holds them returns the status word supplied on `status_i`. A reseed happens in two cases: a control write that requests a reseed, or an accepted test-seed bit. The block then captures the combined value on `seed_o` and pulses `reseed_o` one cycle later. An accepted test-seed bit also pulses `gen_o` in the cycle after that, asking the generator to produce output. The `HW_REV` parameter picks between two revisions, which force different control bits to zero.

Top module: `seed_src_top`

## Requirements
- R1: After reset `seed_o` is all zeros, `reseed_o` and `gen_o` are low, the control register reads zero, and the test seed is zero.
- R2: When control bit 3 is set, the upper half `seed_o[767:384]` is the external seed, with word k (offset 0x40+4k) at bits [384+32k+31 : 384+32k]. This holds whatever the state of control bit 6.
- R3: When bit 3 is clear and control bit 6 (test mode) is set, `seed_o[511:384]` holds the 128-bit test seed and `seed_o[767:512]` is zero.
- R4: When bits 3 and 6 are both clear, the upper half is `entropy_i` as sampled at the capture edge.
- R5: The lower half `seed_o[383:0]` holds personalization word k (offset 0x80+4k) at bits [32k+31:32k], or all zeros while control bit 10 is set.
- R6: A read of any offset from 0x40 to 0xAC returns `status_i` one cycle after the read. A read of 0x08 returns the control register, and other offsets read as zero.
- R7: A write to offset 0x14 shifts the 128-bit test seed left by one. Bit 0 of the written data enters the LSB, and bit 63 moves into bit 64.
- R8: A write to 0x14 has no effect unless test mode is set in the control register and `src_en_i` is high. When ignored, it leaves the test seed unchanged and raises no strobe.
- R9: An accepted test-seed bit causes a reseed carrying the new test seed, followed one cycle after `reseed_o` by a one-cycle `gen_o` pulse.
- R10: A control write with bit 5 set and bit 7 clear causes one reseed without `gen_o`. `seed_o` changes at the edge after the write and `reseed_o` is high for exactly the following cycle. With bit 7 set, no reseed occurs.
- R11: With `HW_REV` below 0x0200, writes to 0x14 are dropped and control bits 10 and 9 always store 0. Otherwise control bits 4 and 1 always store 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | WORD_W | Write data |
| rdata_o | output | WORD_W | Read data, valid the cycle after `rd_en_i` |
| status_i | input | WORD_W | Status word returned for reads of the hidden window |
| src_en_i | input | 1 | Entropy source enabled |
| entropy_i | input | WORD_W*N_WORDS | Raw entropy value |
| seed_o | output | 2*WORD_W*N_WORDS | Captured seed: source half over personalization half |
| reseed_o | output | 1 | One-cycle reseed strobe |
| gen_o | output | 1 | One-cycle generate strobe after a test-seed reseed |

## Verification
The source selector is driven through every control combination that changes the result. These are external alone, external together with test mode (which tells priority apart from plain selection), test mode alone, and neither (entropy). Each is run with the personalization half both enabled and blanked. Seventy test-seed bits are shifted with an irregular bit pattern and junk in the upper write-data bits. This separates a correct left shift and a correct carry across the 64-bit halves from reversed order, lost carry, or use of the wrong data bit. Shift writes made while the source is off or test mode is clear are followed by a deliberate reseed, so that a test seed they wrongly altered shows at the ports. A second instance built with the older revision shows the dropped shift writes and the other set of forced control bits.

// File: rtl/seed_src_pkg.sv
package seed_src_pkg;

   // control register bit positions
   localparam int unsigned CB_LEGA = 1;
   localparam int unsigned CB_EXT  = 3;
   localparam int unsigned CB_LEGB = 4;
   localparam int unsigned CB_GO   = 5;
   localparam int unsigned CB_TST  = 6;
   localparam int unsigned CB_GEN  = 7;
   localparam int unsigned CB_ONE  = 9;
   localparam int unsigned CB_PDIS = 10;

   // byte offsets
   localparam logic [7:0] OFS_CTRL    = 8'h08;
   localparam logic [7:0] OFS_BIT     = 8'h14;
   localparam logic [7:0] OFS_EXT     = 8'h40;
   localparam logic [7:0] OFS_PER     = 8'h80;
   localparam logic [7:0] OFS_HIDE_LO = 8'h40;
   localparam logic [7:0] OFS_HIDE_HI = 8'hAC;

   localparam logic [15:0] REV_SPLIT = 16'h0200;

   typedef enum logic [1:0] {
      SRC_ENT = 2'd0,
      SRC_TST = 2'd1,
      SRC_EXT = 2'd2
   } seed_src_e;

endpackage

// File: rtl/seed_word_bank.sv
module seed_word_bank #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned N_WORDS = 12,
   parameter int unsigned ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] BASE = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [WORD_W-1:0]           wdata_i,
   output logic [WORD_W*N_WORDS-1:0]   words_o
);
   localparam int unsigned STRIDE = WORD_W / 8;

   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("seed_word_bank: WORD_W must be a whole number of bytes");
   end

   for (genvar k = 0; k < N_WORDS; k++) begin : g_word
      localparam logic [ADDR_W-1:0] OFS = BASE + ADDR_W'(k * STRIDE);
      logic [WORD_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en_i && addr_i == OFS)
            q <= wdata_i;
      end

      assign words_o[k*WORD_W +: WORD_W] = q;
   end
endmodule

// File: rtl/seed_tst_shift.sv
module seed_tst_shift #(
   parameter int unsigned TST_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic [TST_W-1:0] tst_o
);
   localparam int unsigned HALF_W = TST_W / 2;

   if (TST_W % 2 != 0 || TST_W < 4) begin : g_bad_tst
      $error("seed_tst_shift: TST_W must be even and at least 4");
   end

   logic [HALF_W-1:0] lo_q;
   logic [HALF_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (shift_i) begin
         lo_q <= {lo_q[HALF_W-2:0], bit_i};
         hi_q <= {hi_q[HALF_W-2:0], lo_q[HALF_W-1]};
      end
   end

   assign tst_o = {hi_q, lo_q};
endmodule

// File: rtl/seed_select.sv
module seed_select
   import seed_src_pkg::*;
#(
   parameter int unsigned SEED_W = 384,
   parameter int unsigned TST_W  = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig_i,
   input  logic                trig_gen_i,
   input  logic                ext_sel_i,
   input  logic                tst_sel_i,
   input  logic                pdis_i,
   input  logic [SEED_W-1:0]   ext_i,
   input  logic [SEED_W-1:0]   pers_i,
   input  logic [TST_W-1:0]    tst_i,
   input  logic [SEED_W-1:0]   ent_i,
   output logic [2*SEED_W-1:0] seed_o,
   output logic                cap_o,
   output logic                reseed_o,
   output logic                gen_o
);
   if (TST_W > SEED_W) begin : g_bad_fit
      $error("seed_select: test seed wider than seed field");
   end

   seed_src_e         src;
   logic [SEED_W-1:0] src_word;
   logic [SEED_W-1:0] pers_word;

   always_comb begin
      if (ext_sel_i)
         src = SRC_EXT;
      else if (tst_sel_i)
         src = SRC_TST;
      else
         src = SRC_ENT;
   end

   always_comb begin
      case (src)
         SRC_EXT: src_word = ext_i;
         SRC_TST: src_word = SEED_W'(tst_i);
         default: src_word = ent_i;
      endcase
   end

   assign pers_word = pdis_i ? '0 : pers_i;

   logic                trig_q, tg1_q, cap_q, tg2_q, reseed_q, tg3_q, gen_q;
   logic [2*SEED_W-1:0] seed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q   <= 1'b0;
         tg1_q    <= 1'b0;
         cap_q    <= 1'b0;
         tg2_q    <= 1'b0;
         reseed_q <= 1'b0;
         tg3_q    <= 1'b0;
         gen_q    <= 1'b0;
         seed_q   <= '0;
      end else begin
         trig_q   <= trig_i;
         tg1_q    <= trig_i & trig_gen_i;
         cap_q    <= trig_q;
         tg2_q    <= tg1_q;
         reseed_q <= cap_q;
         tg3_q    <= tg2_q;
         gen_q    <= tg3_q;
         if (trig_q)
            seed_q <= {src_word, pers_word};
      end
   end

   assign seed_o   = seed_q;
   assign cap_o    = cap_q;
   assign reseed_o = reseed_q;
   assign gen_o    = gen_q;
endmodule

// File: rtl/seed_src_top.sv
module seed_src_top
   import seed_src_pkg::*;
#(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned N_WORDS = 12,
   parameter int unsigned TST_W   = 128,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned CTRL_W  = 11,
   parameter logic [15:0] HW_REV  = 16'h0200,
   localparam int unsigned SEED_W = WORD_W * N_WORDS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic                rd_en_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [WORD_W-1:0]   wdata_i,
   output logic [WORD_W-1:0]   rdata_o,
   input  logic [WORD_W-1:0]   status_i,
   input  logic                src_en_i,
   input  logic [SEED_W-1:0]   entropy_i,
   output logic [2*SEED_W-1:0] seed_o,
   output logic                reseed_o,
   output logic                gen_o
);
   localparam bit LEGACY = (HW_REV < REV_SPLIT);
   localparam int unsigned BANK_SPAN = N_WORDS * (WORD_W / 8);

   if (CTRL_W <= CB_PDIS || CTRL_W > WORD_W) begin : g_bad_ctrl
      $error("seed_src_top: CTRL_W must cover the control bits and fit a word");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("seed_src_top: ADDR_W too narrow for the register map");
   end
   if (BANK_SPAN > 32'h40) begin : g_bad_span
      $error("seed_src_top: seed banks overlap");
   end

   logic [ADDR_W-1:0] ofs_ctrl, ofs_bit, hide_lo, hide_hi;
   assign ofs_ctrl = ADDR_W'(OFS_CTRL);
   assign ofs_bit  = ADDR_W'(OFS_BIT);
   assign hide_lo  = ADDR_W'(OFS_HIDE_LO);
   assign hide_hi  = ADDR_W'(OFS_HIDE_HI);

   // revision-dependent write behaviour
   logic [CTRL_W-1:0] ctrl_keep;
   logic              bit_path_en;

   if (LEGACY) begin : g_rev_old
      assign ctrl_keep   = ~((CTRL_W'(1) << CB_PDIS) | (CTRL_W'(1) << CB_ONE));
      assign bit_path_en = 1'b0;
   end else begin : g_rev_new
      assign ctrl_keep   = ~((CTRL_W'(1) << CB_LEGB) | (CTRL_W'(1) << CB_LEGA));
      assign bit_path_en = 1'b1;
   end

   // control register
   logic [CTRL_W-1:0] ctrl_q;
   logic              ctrl_wr;
   assign ctrl_wr = wr_en_i && (addr_i == ofs_ctrl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (ctrl_wr)
         ctrl_q <= wdata_i[CTRL_W-1:0] & ctrl_keep;
   end

   // reseed requests
   logic shift_en, trig_ctl, trig;
   assign shift_en = wr_en_i && (addr_i == ofs_bit) && bit_path_en
                     && ctrl_q[CB_TST] && src_en_i;
   assign trig_ctl = ctrl_wr && wdata_i[CB_GO] && !wdata_i[CB_GEN];
   assign trig     = shift_en || trig_ctl;

   // storage
   logic [SEED_W-1:0] ext_words, pers_words;
   logic [TST_W-1:0]  tst_seed;

   seed_word_bank #(
      .WORD_W (WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W),
      .BASE   (ADDR_W'(OFS_EXT))
   ) u_ext_bank (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .words_o(ext_words)
   );

   seed_word_bank #(
      .WORD_W (WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W),
      .BASE   (ADDR_W'(OFS_PER))
   ) u_pers_bank (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .words_o(pers_words)
   );

   seed_tst_shift #(.TST_W(TST_W)) u_tst (
      .clk(clk), .rst_n(rst_n), .shift_i(shift_en), .bit_i(wdata_i[0]),
      .tst_o(tst_seed)
   );

   logic cap_w;

   seed_select #(.SEED_W(SEED_W), .TST_W(TST_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_i    (trig),
      .trig_gen_i(shift_en),
      .ext_sel_i (ctrl_q[CB_EXT]),
      .tst_sel_i (ctrl_q[CB_TST]),
      .pdis_i    (ctrl_q[CB_PDIS]),
      .ext_i     (ext_words),
      .pers_i    (pers_words),
      .tst_i     (tst_seed),
      .ent_i     (entropy_i),
      .seed_o    (seed_o),
      .cap_o     (cap_w),
      .reseed_o  (reseed_o),
      .gen_o     (gen_o)
   );

   // read path: seed material never leaves the block
   logic [WORD_W-1:0] rdata_q;
   logic              hide_hit;
   assign hide_hit = (addr_i >= hide_lo) && (addr_i <= hide_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_en_i) begin
         if (hide_hit)
            rdata_q <= status_i;
         else if (addr_i == ofs_ctrl)
            rdata_q <= WORD_W'(ctrl_q);
         else
            rdata_q <= '0;
      end
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/seed_src_chk.sv
module seed_src_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned CTRL_W = 11,
   parameter logic [15:0] HW_REV = 16'h0200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [WORD_W-1:0] status_i,
   input logic [WORD_W-1:0] rdata_o,
   input logic              cap_w,
   input logic              reseed_o,
   input logic              gen_o,
   input logic [CTRL_W-1:0] ctrl_q
);
   localparam logic [CTRL_W-1:0] FORBID = (HW_REV < 16'h0200)
      ? ((CTRL_W'(1) << 10) | (CTRL_W'(1) << 9))
      : ((CTRL_W'(1) << 4)  | (CTRL_W'(1) << 1));

   // R6
   hidden_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i && (addr_i >= ADDR_W'(8'h40)) && (addr_i <= ADDR_W'(8'hAC))
      |=> rdata_o == $past(status_i));

   // R10
   strobe_follows_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_w |=> reseed_o);

   // R10
   strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reseed_o |-> $past(cap_w));

   // R9
   gen_after_reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_o |-> $past(reseed_o));

   // R11
   rev_forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & FORBID) == '0);
endmodule

bind seed_src_top seed_src_chk #(
   .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CTRL_W(CTRL_W), .HW_REV(HW_REV)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .addr_i(addr_i),
   .status_i(status_i), .rdata_o(rdata_o), .cap_w(cap_w),
   .reseed_o(reseed_o), .gen_o(gen_o), .ctrl_q(ctrl_q)
);

// File: tb/seed_src_top_tb.sv
module seed_src_top_tb;
   localparam int SW = 384;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          wr_en = 0, rd_en = 0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [31:0]   status = '0;
   logic          src_en = 0;
   logic [SW-1:0] entropy = '0;
   logic [2*SW-1:0] seed;
   logic          reseed, gen;

   logic          o_wr_en = 0, o_rd_en = 0;
   logic [7:0]    o_addr = '0;
   logic [31:0]   o_wdata = '0;
   logic [31:0]   o_rdata;
   logic [2*SW-1:0] o_seed;
   logic          o_reseed, o_gen;

   seed_src_top u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .status_i(status), .src_en_i(src_en),
      .entropy_i(entropy), .seed_o(seed), .reseed_o(reseed), .gen_o(gen)
   );

   seed_src_top #(.HW_REV(16'h0100)) u_old (
      .clk(clk), .rst_n(rst_n), .wr_en_i(o_wr_en), .rd_en_i(o_rd_en), .addr_i(o_addr),
      .wdata_i(o_wdata), .rdata_o(o_rdata), .status_i(status), .src_en_i(src_en),
      .entropy_i(entropy), .seed_o(o_seed), .reseed_o(o_reseed), .gen_o(o_gen)
   );

   int vectors = 0;
   int miscompares = 0;

   typedef struct packed {
      logic [2*SW-1:0] seed;
      logic            gen;
   } exp_t;
   exp_t exp_q[$];

   logic [SW-1:0]  sh_ext = '0, sh_per = '0;
   logic [127:0]   sh_tst = '0;
   logic [10:0]    sh_ctrl = '0;

   function automatic logic [2*SW-1:0] model(input logic [10:0] c);
      logic [SW-1:0] s, p;
      if (c[3])      s = sh_ext;
      else if (c[6]) s = {256'b0, sh_tst};
      else           s = entropy;
      p = c[10] ? '0 : sh_per;
      return {s, p};
   endfunction

   task automatic check(input bit ok, input string req, input logic [2*SW-1:0] act,
                        input logic [2*SW-1:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: updates the model and pushes expected reseeds
   task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
      if (a >= 8'h40 && a < 8'h70) sh_ext[(a-8'h40)*8 +: 32] = d;
      if (a >= 8'h80 && a < 8'hB0) sh_per[(a-8'h80)*8 +: 32] = d;
      if (a == 8'h14 && sh_ctrl[6] && src_en) begin
         sh_tst = {sh_tst[126:0], d[0]};
         exp_q.push_back('{seed: model(sh_ctrl), gen: 1'b1});
      end
      if (a == 8'h08) begin
         sh_ctrl = d[10:0] & ~11'h012;
         if (d[5] && !d[7]) exp_q.push_back('{seed: model(sh_ctrl), gen: 1'b0});
      end
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string req);
      @(negedge clk);
      rd_en = 1; addr = a;
      @(negedge clk);
      rd_en = 0;
      check(rdata == e, req, (2*SW)'(rdata), (2*SW)'(e));
   endtask

   task automatic o_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      o_wr_en = 1; o_addr = a; o_wdata = d;
      @(negedge clk);
      o_wr_en = 0;
   endtask

   task automatic o_rd(input logic [7:0] a, input logic [31:0] e, input string req);
      @(negedge clk);
      o_rd_en = 1; o_addr = a;
      @(negedge clk);
      o_rd_en = 0;
      check(o_rdata == e, req, (2*SW)'(o_rdata), (2*SW)'(e));
   endtask

   // monitor: pops expected reseeds as the design raises its strobes
   bit gen_pend = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (gen_pend)
            check(gen == 1'b1, "R9 gen after shift reseed", (2*SW)'(gen), 1);
         else if (gen)
            check(1'b0, "R9 unexpected gen", 1, 0);
         gen_pend = 0;
         if (reseed) begin
            if (exp_q.size() == 0)
               check(1'b0, "R8/R10 unexpected reseed", seed, '0);
            else begin
               exp_t it;
               it = exp_q.pop_front();
               check(seed == it.seed, "R2-R5 seed value", seed, it.seed);
               gen_pend = it.gen;
            end
         end
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(seed == '0 && !reseed && !gen, "R1 reset outputs", seed, '0);
      chk_rd(8'h08, 32'h0, "R1 ctrl reset");

      for (int k = 0; k < 12; k++) begin
         do_wr(8'h40 + 8'(4*k), {8'hE0, 8'(k), 16'h5A5A});
         do_wr(8'h80 + 8'(4*k), {8'hB0, 8'(k), 16'h3C3C});
      end
      for (int k = 0; k < 12; k++) entropy[k*32 +: 32] = 32'h9E3779B9 * (k + 1);

      do_wr(8'h08, 32'h028);   // R2 R5 R10 external seed
      do_wr(8'h08, 32'h428);   // R5 personalization blanked
      do_wr(8'h08, 32'h020);   // R4 entropy
      do_wr(8'h08, 32'h068);   // R2 external beats test mode
      do_wr(8'h08, 32'h0A0);   // R10 start with generate bit: no reseed

      // R7 R9 R3 shift 70 bits, crossing the half boundary
      do_wr(8'h08, 32'h040);
      src_en = 1;
      for (int i = 0; i < 70; i++)
         do_wr(8'h14, 32'hFFFF_FFF0 | 32'(((i * 5) % 7) < 3));

      // R8 source disabled: shift ignored
      src_en = 0;
      do_wr(8'h14, 32'h1);
      do_wr(8'h08, 32'h060);
      // R8 test mode off: shift ignored
      src_en = 1;
      do_wr(8'h08, 32'h000);
      do_wr(8'h14, 32'h1);
      do_wr(8'h08, 32'h060);

      // R11 newer revision forces bits 4 and 1
      do_wr(8'h08, 32'h652);
      chk_rd(8'h08, 32'h640, "R11 new-rev ctrl");

      // R6 hidden window
      status = 32'hC0FF_EE01; chk_rd(8'h40, 32'hC0FF_EE01, "R6 read 0x40");
      status = 32'h1357_9BDF; chk_rd(8'h7C, 32'h1357_9BDF, "R6 read 0x7C");
      status = 32'h2468_ACE0; chk_rd(8'hAC, 32'h2468_ACE0, "R6 read 0xAC");
      chk_rd(8'h3C, 32'h0, "R6 unmapped reads zero");

      // R11 older revision
      o_wr(8'h80, 32'h1234_5678);
      o_wr(8'h08, 32'h652);
      o_rd(8'h08, 32'h052, "R11 old-rev ctrl");
      o_wr(8'h14, 32'h1);
      o_wr(8'h08, 32'h072);
      @(negedge clk);
      @(negedge clk);
      check(o_reseed == 1'b1, "R11 old-rev reseed", (2*SW)'(o_reseed), 1);
      check(o_seed == (2*SW)'(32'h1234_5678), "R11 old-rev shift dropped", o_seed,
            (2*SW)'(32'h1234_5678));
      @(negedge clk);
      check(o_gen == 1'b0, "R11 old-rev no gen", (2*SW)'(o_gen), 0);

      repeat (8) @(negedge clk);
      check(exp_q.size() == 0, "R10 missing reseed", (2*SW)'(exp_q.size()), 0);
      finish_run();
   end
endmodule